// File: doc/BRIEF.md
# Card ID Frame Assembler and Access Lookup

This block sits behind a byte-wide serial receiver and turns its output into an access decision. The receiver presents a byte together with a valid level. The block takes each byte once, on the rising edge of that level. It hunts for a line-feed start byte and gathers the ten ASCII characters that follow into an 80-bit card ID. It then checks the character after them, which must be a carriage return.

When the frame is complete and correctly terminated, the assembled ID is compared against a small table of trusted cards that is fixed at build time. The block then presents four outputs: the ID, a grant flag, a 3-bit user code, and a 20-character space-padded ASCII name. On a match the name is the card holder's. Otherwise the grant flag is low, the user code is zero and the name is a fixed denial message. A frame with a bad terminator changes nothing.

Top module: `card_access_unit`

## Requirements
- R1: After reset, `grant` is 0, `user_code` is 0, `id_out` is all zeros and `name_out` holds "ACCESS DENIED!" followed by six spaces (first character in bits 159:152).
- R2: A byte is taken only on the clock where `rx_valid` goes from 0 to 1; while `rx_valid` stays high, changes on `rx_byte` are not taken.
- R3: Bytes taken while no frame is open are ignored until the start byte 0x0A arrives.
- R4: The ten bytes after 0x0A form the ID: the first byte lands in bits 79:72, the tenth in bits 7:0.
- R5: The byte taken after the tenth ID byte must be 0x0D for the frame to be looked up; any other value drops the frame and all outputs keep their previous values.
- R6: A 0x0A taken in the middle of a frame (during the ID bytes or in the terminator slot) throws away the partial frame and starts a new one.
- R7: On a table match, `grant` is 1, `user_code` is the entry's code and `name_out` is the entry's name, padded with spaces (0x20) on the right to 20 characters.
- R8: On a miss, `grant` is 0, `user_code` is 0, `name_out` is the denial string of R1, and `id_out` still shows the received ID.
- R9: The outputs change on the second rising clock edge counted from the edge that takes the 0x0D terminator, and not on that edge itself.
- R10: The table has four entries: "0F02782BC2" with code 3'b010, "0F02782068" with code 3'b011, "1A4C00D9E7" with code 3'b100 and "0415F22B03" with code 3'b110. Each ID is written as ASCII with the first character most significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | Valid level from the receiver; its rising edge marks a new byte |
| id_out | output | 80 | Last correctly terminated card ID |
| grant | output | 1 | High when that ID is in the trusted table |
| user_code | output | 3 | Code of the matching entry, zero on a miss |
| name_out | output | 160 | 20-character ASCII name or the denial message |

## Verification
The assertions assume that `rx_valid` drops between bytes. The pulse derived from its rising edge can therefore never stay high on two neighbouring cycles. They also assume that the outputs move only in the cycle after a frame is committed. The stimulus meets these conditions: every byte is sent as one high cycle of `rx_valid` followed by one low cycle. The exception is the case that holds the level high on purpose, and that case still lets it fall before the next byte. The tests cover a frame arriving after stray bytes, a restart in the middle of a frame, a wrong terminator, and every table entry in turn.

// File: rtl/card_pkg.sv
// Package: shared widths, framing bytes and the trusted-card table.
// Assumes ASCII text is packed with the first character in the top byte.
package card_pkg;

    localparam int BYTE_W     = 8;
    localparam int ID_DIGITS  = 10;
    localparam int ID_W       = BYTE_W * ID_DIGITS;
    localparam int NAME_CHARS = 20;
    localparam int NAME_W     = BYTE_W * NAME_CHARS;
    localparam int CODE_W     = 3;
    localparam int N_USERS    = 4;

    localparam logic [BYTE_W-1:0] SOF_BYTE = 8'h0A;
    localparam logic [BYTE_W-1:0] EOF_BYTE = 8'h0D;
    localparam logic [BYTE_W-1:0] PAD_BYTE = 8'h20;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [CODE_W-1:0] code;
        logic [NAME_W-1:0] name;
    } user_rec_t;

    // Left-justify a short literal and fill the tail with spaces.
    function automatic logic [NAME_W-1:0] pad_text(input logic [NAME_W-1:0] s);
        int  lead;
        bit  seen;
        lead = 0;
        seen = 1'b0;
        for (int k = NAME_CHARS - 1; k >= 0; k--) begin
            if (!seen && s[k*BYTE_W +: BYTE_W] == '0)
                lead++;
            else
                seen = 1'b1;
        end
        return (s << (lead * BYTE_W)) |
               ({NAME_CHARS{PAD_BYTE}} >> ((NAME_CHARS - lead) * BYTE_W));
    endfunction

    localparam logic [NAME_W-1:0] DENY_TEXT = pad_text("ACCESS DENIED!");

    // Trusted card table, one record per index.
    function automatic user_rec_t user_entry(input int idx);
        user_rec_t r;
        r.id   = '0;
        r.code = '0;
        r.name = DENY_TEXT;
        case (idx)
            0: begin r.id = "0F02782BC2"; r.code = 3'b010; r.name = pad_text("HARPER QUINN"); end
            1: begin r.id = "0F02782068"; r.code = 3'b011; r.name = pad_text("DEVON OKAFOR"); end
            2: begin r.id = "1A4C00D9E7"; r.code = 3'b100; r.name = pad_text("LENA MARSH");   end
            3: begin r.id = "0415F22B03"; r.code = 3'b110; r.name = pad_text("RUI TANAKA");   end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/byte_strobe.sv
// Module: byte_strobe
// Turns the receiver's valid level into a one-cycle take pulse on its
// rising edge. Assumes the level falls between consecutive bytes.
module byte_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_lvl,
    output logic take
);
    logic prev_q;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= valid_lvl;
    end

    // Pulse only on a low-to-high step.
    assign take = valid_lvl & ~prev_q;
endmodule

// File: rtl/id_framer.sv
// Module: id_framer
// Hunts for the start byte, shifts in the ID characters first-most-significant,
// and checks the terminator. Emits a one-cycle commit with the held ID.
// Assumes take pulses are at least two cycles apart.
module id_framer #(
    parameter int BW     = card_pkg::BYTE_W,
    parameter int DIGITS = card_pkg::ID_DIGITS,
    parameter logic [BW-1:0] SOF = card_pkg::SOF_BYTE,
    parameter logic [BW-1:0] EOF = card_pkg::EOF_BYTE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [BW-1:0]    byte_in,
    output logic [BW*DIGITS-1:0] frame_id,
    output logic             frame_ok
);
    localparam int FW    = BW * DIGITS;
    localparam int CNT_W = $clog2(DIGITS + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DIGITS - 1);

    typedef enum logic [1:0] {HUNT, DIGIT, TAIL} phase_t;

    phase_t            phase;
    logic [CNT_W-1:0]  slot;
    logic [FW-1:0]     acc;

    // Frame sequencing: start byte always reopens, else advance by phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= HUNT;
            slot     <= '0;
            acc      <= '0;
            frame_id <= '0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= 1'b0;
            if (take) begin
                if (byte_in == SOF) begin
                    phase <= DIGIT;
                    slot  <= '0;
                end else begin
                    case (phase)
                        HUNT: ;
                        DIGIT: begin
                            acc  <= {acc[FW-BW-1:0], byte_in};
                            slot <= slot + 1'b1;
                            if (slot == LAST_SLOT) phase <= TAIL;
                        end
                        TAIL: begin
                            if (byte_in == EOF) begin
                                frame_id <= acc;
                                frame_ok <= 1'b1;
                            end
                            phase <= HUNT;
                        end
                        default: phase <= HUNT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/trust_lookup.sv
// Module: trust_lookup
// Compares an ID with every table entry in parallel and returns the
// lowest-index hit with its code and name. Purely combinational.
module trust_lookup #(
    parameter int ID_W    = card_pkg::ID_W,
    parameter int CODE_W  = card_pkg::CODE_W,
    parameter int NAME_W  = card_pkg::NAME_W,
    parameter int N_USERS = card_pkg::N_USERS
) (
    input  logic [ID_W-1:0]   id_in,
    output logic              hit,
    output logic [CODE_W-1:0] code,
    output logic [NAME_W-1:0] name
);
    logic [N_USERS-1:0]  match;
    logic [CODE_W-1:0]   code_tab [N_USERS];
    logic [NAME_W-1:0]   name_tab [N_USERS];

    // One comparator per table entry.
    for (genvar g = 0; g < N_USERS; g++) begin : g_entry
        localparam card_pkg::user_rec_t REC = card_pkg::user_entry(g);
        assign match[g]    = (id_in == REC.id);
        assign code_tab[g] = REC.code;
        assign name_tab[g] = REC.name;
    end

    // Priority pick of the lowest matching index.
    always_comb begin
        hit  = 1'b0;
        code = '0;
        name = card_pkg::DENY_TEXT;
        for (int k = N_USERS - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit  = 1'b1;
                code = code_tab[k];
                name = name_tab[k];
            end
        end
    end
endmodule

// File: rtl/card_access_unit.sv
// Module: card_access_unit (top)
// Receiver byte stream in, access decision out. Outputs are registered and
// move one clock after a committed frame; reset leaves the deny state.
module card_access_unit (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   rx_byte,
    input  logic         rx_valid,
    output logic [79:0]  id_out,
    output logic         grant,
    output logic [2:0]   user_code,
    output logic [159:0] name_out
);
    import card_pkg::*;

    logic              stb_w;
    logic              frame_ok_w;
    logic [ID_W-1:0]   frame_id_w;
    logic              hit_w;
    logic [CODE_W-1:0] code_w;
    logic [NAME_W-1:0] name_w;

    byte_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_lvl (rx_valid),
        .take      (stb_w)
    );

    id_framer #(.BW(BYTE_W), .DIGITS(ID_DIGITS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (stb_w),
        .byte_in  (rx_byte),
        .frame_id (frame_id_w),
        .frame_ok (frame_ok_w)
    );

    trust_lookup #(.ID_W(ID_W), .CODE_W(CODE_W), .NAME_W(NAME_W), .N_USERS(N_USERS)) u_lookup (
        .id_in (frame_id_w),
        .hit   (hit_w),
        .code  (code_w),
        .name  (name_w)
    );

    // Result registers: load on commit, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_out    <= '0;
            grant     <= 1'b0;
            user_code <= '0;
            name_out  <= DENY_TEXT;
        end else if (frame_ok_w) begin
            id_out    <= frame_id_w;
            grant     <= hit_w;
            user_code <= hit_w ? code_w : '0;
            name_out  <= hit_w ? name_w : DENY_TEXT;
        end
    end
endmodule

// File: rtl/card_access_chk.sv
// Module: card_access_chk
// Property checks for card_access_unit, attached by bind below.
module card_access_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         stb,
    input logic         commit,
    input logic [79:0]  id_out,
    input logic         grant,
    input logic [2:0]   user_code,
    input logic [159:0] name_out
);
    // True when the ID is one of the table entries.
    function automatic bit in_table(input logic [79:0] id);
        bit f;
        f = 1'b0;
        for (int k = 0; k < card_pkg::N_USERS; k++)
            if (card_pkg::user_entry(k).id == id) f = 1'b1;
        return f;
    endfunction

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R2

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(id_out) && $stable(grant) && $stable(user_code) && $stable(name_out))); // R5

    AST_GRANT_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (user_code != 3'b000)); // R7

    AST_DENY_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (user_code == 3'b000 && name_out == card_pkg::DENY_TEXT)); // R8

    AST_GRANT_KNOWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> in_table(id_out)); // R10
endmodule

bind card_access_unit card_access_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb_w),
    .commit    (frame_ok_w),
    .id_out    (id_out),
    .grant     (grant),
    .user_code (user_code),
    .name_out  (name_out)
);

// File: tb/sim_card_access_unit.sv
`timescale 1ns/1ps
module sim_card_access_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   rx_byte = 8'h00;
    logic         rx_valid = 1'b0;
    logic [79:0]  id_out;
    logic         grant;
    logic [2:0]   user_code;
    logic [159:0] name_out;

    int n_total = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    card_access_unit u0 (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .id_out(id_out), .grant(grant), .user_code(user_code), .name_out(name_out)
    );

    localparam logic [159:0] DENY = {"ACCESS DENIED!", {6{8'h20}}};
    localparam logic [79:0]  ID_A = "0F02782BC2";
    localparam logic [79:0]  ID_B = "0F02782068";
    localparam logic [79:0]  ID_C = "1A4C00D9E7";
    localparam logic [79:0]  ID_D = "0415F22B03";
    localparam logic [159:0] NM_A = {"HARPER QUINN", {8{8'h20}}};
    localparam logic [159:0] NM_B = {"DEVON OKAFOR", {8{8'h20}}};
    localparam logic [159:0] NM_C = {"LENA MARSH", {10{8'h20}}};
    localparam logic [159:0] NM_D = {"RUI TANAKA", {10{8'h20}}};

    task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [79:0] id, input bit g,
                           input logic [2:0] c, input logic [159:0] nm);
        chk(id_out == id,      req, {80'h0, id_out},    {80'h0, id});
        chk(grant == g,        req, {159'h0, grant},    {159'h0, g});
        chk(user_code == c,    req, {157'h0, user_code},{157'h0, c});
        chk(name_out == nm,    req, name_out,           nm);
    endtask

    // One byte: one high cycle then one low cycle of rx_valid.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_digits(input logic [79:0] id);
        for (int k = 9; k >= 0; k--) send_byte(id[k*8 +: 8]);
    endtask

    task automatic send_frame(input logic [79:0] id);
        send_byte(8'h0A);
        send_digits(id);
        send_byte(8'h0D);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk_all("R1", 80'h0, 1'b0, 3'b000, DENY);
    endtask

    task automatic t_table;
        send_frame(ID_A); chk_all("R7 R10 R4 entry A", ID_A, 1'b1, 3'b010, NM_A);
        send_frame(ID_B); chk_all("R7 R10 entry B", ID_B, 1'b1, 3'b011, NM_B);
        send_frame(ID_C); chk_all("R7 R10 entry C", ID_C, 1'b1, 3'b100, NM_C);
        send_frame(ID_D); chk_all("R7 R10 entry D", ID_D, 1'b1, 3'b110, NM_D);
    endtask

    task automatic t_miss;
        send_frame("9999999999");
        chk_all("R8 miss", "9999999999", 1'b0, 3'b000, DENY);
        chk(id_out[79:72] == "9" && id_out[7:0] == "9", "R4 byte order", {80'h0, id_out}, {80'h0, 80'h0});
    endtask

    task automatic t_bad_term;
        send_frame(ID_A);
        send_byte(8'h0A); send_digits(ID_C); send_byte(8'h0E);
        @(negedge clk);
        chk_all("R5 wrong terminator", ID_A, 1'b1, 3'b010, NM_A);
        send_byte(8'h0D);
        @(negedge clk);
        chk_all("R5 stray terminator", ID_A, 1'b1, 3'b010, NM_A);
    endtask

    task automatic t_restart;
        send_frame("1111111111");
        send_byte(8'h0A);
        send_byte("0"); send_byte("F"); send_byte("0");
        send_byte(8'h0A);
        send_digits(ID_B);
        send_byte(8'h0D);
        @(negedge clk);
        chk_all("R6 restart in digits", ID_B, 1'b1, 3'b011, NM_B);
        send_byte(8'h0A); send_digits("2222222222"); send_byte(8'h0A);
        send_digits(ID_D); send_byte(8'h0D);
        @(negedge clk);
        chk_all("R6 restart at terminator", ID_D, 1'b1, 3'b110, NM_D);
    endtask

    task automatic t_prefix;
        send_byte("7"); send_byte("C"); send_byte(8'h0D);
        send_frame(ID_C);
        chk_all("R3 bytes before start", ID_C, 1'b1, 3'b100, NM_C);
    endtask

    task automatic t_hold_valid;
        send_byte(8'h0A);
        @(negedge clk);
        rx_byte = "5"; rx_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_byte = "9";
        end
        rx_valid = 1'b0;
        @(negedge clk);
        send_digits({8'h00, "123456789"} << 0 | 80'h0);
        // above sends a NUL first; restart cleanly instead
        send_byte(8'h0A);
        @(negedge clk);
        rx_byte = "5"; rx_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_byte = "9";
        end
        rx_valid = 1'b0;
        @(negedge clk);
        for (int k = 8; k >= 0; k--) send_byte(("123456789" >> (k*8)) & 8'hFF);
        send_byte(8'h0D);
        @(negedge clk);
        chk_all("R2 held valid taken once", "5123456789", 1'b0, 3'b000, DENY);
    endtask

    task automatic t_latency;
        send_frame("3333333333");
        send_byte(8'h0A);
        send_digits(ID_A);
        @(negedge clk);
        rx_byte = 8'h0D; rx_valid = 1'b1;
        @(negedge clk);
        chk(grant == 1'b0, "R9 no change on taking edge", {159'h0, grant}, 160'h0);
        rx_valid = 1'b0;
        @(negedge clk);
        chk(grant == 1'b1 && id_out == ID_A, "R9 change one clock later", {79'h0, grant, id_out}, {79'h0, 1'b1, ID_A});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_table;
        t_miss;
        t_bad_term;
        t_restart;
        t_prefix;
        t_hold_valid;
        t_latency;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule